// File: doc/BRIEF.md
# Clock-Synchronous Serial Master

This block moves one byte at a time over a three-wire synchronous link and drives the link's clock itself. A byte offered on the transmit stream goes out serially on `sdo`. During the same 8 clock pulses a byte is collected from `sdi`. When the exchange ends, the received byte is presented for one cycle on the receive side. The transfer clock `sck` rests high whenever the block is idle.

Each transfer takes its line format from configuration pins, sampled on the cycle the byte is accepted:
- **Polarity.** Picks which `sck` edge launches data and which edge captures it.
- **Bit order.** Sends and receives LSB first or MSB first.
- **Inversion.** Complements the data in both directions.
- **Half-period.** Sets the length of each half of the `sck` period in system clocks.

The transmit side is a valid/ready stream. A byte is taken on any rising edge of `clk` where `tx_valid` and `tx_ready` are both high. `tx_ready` is low for the whole transfer, which back-pressures the producer. A producer may hold `tx_valid` high with a byte while `tx_ready` is low; nothing is taken until `tx_ready` returns. The receive side has no back-pressure. `rx_valid` is a one-cycle pulse, and `rx_data` holds its value until the next transfer completes.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, and whenever no transfer is running, `sck` is 1 and `tx_ready` is 1. Reset also sets `rx_valid` to 0, `rx_data` to 0x00 and `sdo` to 1.
- R2: A transfer starts on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until the transfer ends. While `tx_ready` is 0, `tx_valid` and `tx_data` have no effect on the bits sent or on the received byte.
- R3: With `cfg_pol`=0, `sdo` changes only on falling edges of `sck`, and `sdi` is sampled on rising edges. The first falling edge occurs on the accepting clock edge.
- R4: With `cfg_pol`=1, `sdo` changes only on rising edges of `sck`, and `sdi` is sampled on falling edges. The first bit is on `sdo` from the accepting edge onward, so it is valid before the first falling edge.
- R5: Each transfer has exactly 8 capture edges. Every `sck` half-period lasts H = max(`cfg_half_div`, 1) cycles of `clk`, so the transfer spans 16·H cycles.
- R6: With `cfg_msb_first`=0, line bit k (k = 0 for the first bit) carries data bit k, in both directions.
- R7: With `cfg_msb_first`=1, line bit k carries data bit 7−k, in both directions.
- R8: With `cfg_invert`=1, every bit placed on `sdo` is the complement of the `tx_data` bit, and `rx_data` is the complement of the sampled line bits. With `cfg_invert`=0, data passes unchanged.
- R9: Exactly 16·H clock cycles after the accepting edge, `rx_valid` is 1 for one cycle. In that cycle `rx_data` carries the received byte, `sck` is 1 and `tx_ready` is 1. `rx_data` holds its value afterwards.
- R10: `cfg_pol`, `cfg_msb_first`, `cfg_invert` and `cfg_half_div` are sampled only on the accepting edge. Changing them during a transfer does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pol | input | 1 | 0: launch on falling edge, capture on rising edge; 1: the reverse |
| cfg_msb_first | input | 1 | 0: LSB first; 1: MSB first |
| cfg_invert | input | 1 | 1: complement data in both directions |
| cfg_half_div | input | HDIV_W | `sck` half-period in `clk` cycles (0 is treated as 1) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block idle and able to accept a byte |
| tx_data | input | DATA_W | Byte to send |
| rx_valid | output | 1 | One-cycle pulse: received byte available |
| rx_data | output | DATA_W | Last received byte |
| sck | output | 1 | Transfer clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Every result is timed from the accepting clock edge:
- `sck` with `cfg_pol`=0, and `sdo`, show their first new value in the cycle right after that edge.
- Capture edges follow at odd multiples of H cycles.
- `rx_valid` is due exactly 16·H cycles later.

The bench samples on the falling edge of `clk` and numbers each sample by its distance from the accepting edge. It compares `sdo` at each capture edge against the bit computed for that line position. It flags any `sdo` change that does not line up with a launch edge. It requires the single `rx_valid` sample at index 16·H, with `rx_data` held on the two samples after it.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Line format sampled when a transfer is accepted.
  typedef struct packed {
    logic pol;
    logic msb_first;
    logic invert;
  } ssm_fmt_t;

endpackage

// File: rtl/ssm_phase_gen.sv
module ssm_phase_gen #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_pol,
  input  logic [HDIV_W-1:0] start_half,
  output logic              busy,
  output logic              sck,
  output logic              shift_tx,
  output logic              capture,
  output logic              done
);

  localparam int unsigned PHASES = 2 * DATA_W;
  localparam int unsigned PH_W   = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [HDIV_W-1:0] half_q;
  logic [HDIV_W-1:0] hcnt_q;
  logic [PH_W-1:0]   ph_q;
  logic              busy_q;
  logic              sck_q;
  logic              tick;

  // tick: the current half-period ends on this edge
  assign tick     = busy_q && (hcnt_q == (half_q - HDIV_W'(1)));
  // entering an odd phase is a capture edge
  assign capture  = tick && !ph_q[0];
  // entering an even phase (other than the first) launches the next bit
  assign shift_tx = tick && ph_q[0] && (ph_q != LAST_PH);
  assign done     = tick && (ph_q == LAST_PH);
  assign busy     = busy_q;
  assign sck      = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b1;
      half_q <= HDIV_W'(1);
      hcnt_q <= '0;
      ph_q   <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      half_q <= (start_half == '0) ? HDIV_W'(1) : start_half;
      hcnt_q <= '0;
      ph_q   <= '0;
      sck_q  <= start_pol;
    end else if (busy_q) begin
      if (tick) begin
        hcnt_q <= '0;
        if (ph_q == LAST_PH) begin
          busy_q <= 1'b0;
          sck_q  <= 1'b1;
        end else begin
          ph_q  <= ph_q + PH_W'(1);
          sck_q <= ~sck_q;
        end
      end else begin
        hcnt_q <= hcnt_q + HDIV_W'(1);
      end
    end
  end

  // R5: sck moves only when a half-period has run out
  assert_sck_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sck_q));

  // R1: idle clock level is high
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck_q);

endmodule

// File: rtl/ssm_tx_shift.sv
module ssm_tx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              shift,
  output logic              sdo
);

  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] sh_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = load_data[DATA_W-1-i];
  end

  // Put the first line bit at position 0 and apply inversion.
  assign word = (msb_first ? rev : load_data) ^ {DATA_W{invert}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (load) begin
      sh_q <= word;
    end else if (shift) begin
      sh_q <= {1'b1, sh_q[DATA_W-1:1]};
    end
  end

  assign sdo = sh_q[0];

  // R3 and R4: the data line moves only at a load or at a launch edge
  assert_sdo_only_at_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sdo));

endmodule

// File: rtl/ssm_rx_shift.sv
module ssm_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              sdi,
  input  logic              finish,
  input  logic              msb_first,
  input  logic              invert,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int unsigned CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic [CW-1:0]     cap_cnt_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = sh_q[DATA_W-1-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= finish;
      if (capture) begin
        sh_q <= {sdi, sh_q[DATA_W-1:1]};
      end
      if (finish) begin
        data_q <= (msb_first ? rev : sh_q) ^ {DATA_W{invert}};
      end
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;

  // Capture counter used only by the checks below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt_q <= '0;
    end else if (finish) begin
      cap_cnt_q <= '0;
    end else if (capture) begin
      cap_cnt_q <= cap_cnt_q + CW'(1);
    end
  end

  // R5: a transfer ends after exactly DATA_W samples
  assert_full_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (cap_cnt_q == CW'(DATA_W)));

  // R9: completion is a single-cycle pulse
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pol,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic [HDIV_W-1:0] cfg_half_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi
);

  import ssm_pkg::*;

  ssm_fmt_t fmt_q;
  logic     busy;
  logic     accept;
  logic     shift_tx;
  logic     capture;
  logic     done;

  assign tx_ready = !busy;
  assign accept   = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0;
    end else if (accept) begin
      fmt_q <= '{pol: cfg_pol, msb_first: cfg_msb_first, invert: cfg_invert};
    end
  end

  ssm_phase_gen #(.DATA_W(DATA_W), .HDIV_W(HDIV_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_pol  (cfg_pol),
    .start_half (cfg_half_div),
    .busy       (busy),
    .sck        (sck),
    .shift_tx   (shift_tx),
    .capture    (capture),
    .done       (done)
  );

  ssm_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .shift     (shift_tx),
    .sdo       (sdo)
  );

  ssm_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .sdi       (sdi),
    .finish    (done),
    .msb_first (fmt_q.msb_first),
    .invert    (fmt_q.invert),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

  // R2: an accepted byte makes the block busy on the next cycle
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_ready);

  // R9: completion coincides with idle clock and ready
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (tx_ready && sck));

endmodule

// File: tb/sync_serial_master_tb_top.sv
module sync_serial_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_pol = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       cfg_invert = 1'b0;
  logic [7:0] cfg_half_div = 8'd1;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       sck;
  logic       sdo;
  logic       sdi = 1'b0;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  sync_serial_master #(.DATA_W(8), .HDIV_W(8)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_pol       (cfg_pol),
    .cfg_msb_first (cfg_msb_first),
    .cfg_invert    (cfg_invert),
    .cfg_half_div  (cfg_half_div),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .sck           (sck),
    .sdo           (sdo),
    .sdi           (sdi)
  );

  // {pol, msb_first, invert, half[3:0], tx byte, byte the slave returns}
  localparam int NVEC = 8;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 4'd1, 8'h96, 8'h3C},
    {1'b1, 1'b0, 1'b0, 4'd1, 8'h96, 8'h3C},
    {1'b0, 1'b1, 1'b0, 4'd2, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b0, 4'd3, 8'hC3, 8'h5A},
    {1'b0, 1'b0, 1'b1, 4'd2, 8'hF0, 8'h0F},
    {1'b1, 1'b1, 1'b1, 4'd1, 8'h6B, 8'hD2},
    {1'b0, 1'b1, 1'b1, 4'd0, 8'h00, 8'hFF},
    {1'b1, 1'b0, 1'b1, 4'd4, 8'hFF, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic line_bit(input logic [7:0] v, input logic msb, input int k);
    return msb ? v[7-k] : v[k];
  endfunction

  task automatic run_xfer(input logic pol, input logic msb, input logic inv,
                          input logic [7:0] half, input logic [7:0] txd,
                          input logic [7:0] rxv, input bit disturb);
    int   hl = (half == 8'd0) ? 1 : int'(half);
    logic [7:0] tline = inv ? ~txd : txd;
    logic [7:0] rline = inv ? ~rxv : rxv;
    int   ncap = 0;
    int   npulse = 0;
    int   vat = -1;
    logic prev_sck;
    logic prev_sdo;
    @(negedge clk);
    chk(tx_ready === 1'b1 && sck === 1'b1, "R1", "idle before start", {tx_ready, sck}, 2'b11);
    cfg_pol = pol; cfg_msb_first = msb; cfg_invert = inv; cfg_half_div = half;
    tx_data = txd; tx_valid = 1'b1;
    sdi = line_bit(rline, msb, 0);
    prev_sck = 1'b1;
    prev_sdo = sdo;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int idx = 0; idx <= 16 * hl + 2; idx++) begin
      bit fell = prev_sck && !sck;
      bit rose = !prev_sck && sck;
      bit cap_edge = pol ? fell : rose;
      bit lau_edge = pol ? rose : fell;
      if (idx == 0) begin
        chk(sdo === line_bit(tline, msb, 0), pol ? "R4" : "R3", "first bit on sdo",
            sdo, line_bit(tline, msb, 0));
        chk(sck === ~pol ? 1'b0 : 1'b1, pol ? "R4" : "R3", "sck after accept", sck, pol);
      end else if (sdo !== prev_sdo && !lau_edge) begin
        chk(1'b0, pol ? "R4" : "R3", "sdo moved off launch edge", idx, -1);
      end
      if (idx == 1) chk(tx_ready === 1'b0, "R2", "busy during transfer", tx_ready, 0);
      if (cap_edge && idx < 16 * hl) begin
        if (ncap < 8) begin
          chk(sdo === line_bit(tline, msb, ncap), msb ? "R7" : "R6",
              $sformatf("sdo bit %0d inv=%0b", ncap, inv), sdo, line_bit(tline, msb, ncap));
        end
        ncap++;
        if (ncap < 8) sdi = line_bit(rline, msb, ncap);
      end
      if (disturb && idx == 2) begin
        tx_valid = 1'b1; tx_data = ~txd;
        cfg_pol = ~pol; cfg_msb_first = ~msb; cfg_invert = ~inv;
        cfg_half_div = half + 8'd3;
      end
      if (disturb && idx == 16 * hl - 1) tx_valid = 1'b0;
      if (rx_valid === 1'b1) begin
        npulse++;
        vat = idx;
        chk(rx_data === rxv, inv ? "R8" : "R9", "rx_data at done", rx_data, rxv);
        chk(sck === 1'b1 && tx_ready === 1'b1, "R9", "idle at done", {sck, tx_ready}, 2'b11);
      end
      if (idx > 16 * hl) chk(rx_data === rxv, "R9", "rx_data held", rx_data, rxv);
      prev_sck = sck;
      prev_sdo = sdo;
      @(negedge clk);
    end
    chk(ncap == 8, "R5", "capture edge count", ncap, 8);
    chk(npulse == 1, "R9", "rx_valid pulse count", npulse, 1);
    chk(vat == 16 * hl, "R5", "rx_valid cycle", vat, 16 * hl);
    if (disturb) chk(tx_ready === 1'b1, "R10", "no restart after disturb", tx_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sck === 1'b1, "R1", "sck in reset", sck, 1);
    chk(tx_ready === 1'b1, "R1", "tx_ready in reset", tx_ready, 1);
    chk(rx_valid === 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
    chk(rx_data === 8'h00, "R1", "rx_data in reset", rx_data, 0);
    chk(sdo === 1'b1, "R1", "sdo in reset", sdo, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck === 1'b1 && tx_ready === 1'b1, "R1", "idle after reset", {sck, tx_ready}, 2'b11);

    for (int v = 0; v < NVEC; v++) begin
      logic [22:0] e = VEC[v];
      run_xfer(e[22], e[21], e[20], {4'd0, e[19:16]}, e[15:8], e[7:0], 1'b0);
    end

    // R2 and R10: offers and config changes mid-transfer are ignored
    run_xfer(1'b0, 1'b0, 1'b0, 8'd2, 8'hA5, 8'h69, 1'b1);
    run_xfer(1'b1, 1'b1, 1'b1, 8'd1, 8'h3E, 8'hC1, 1'b1);

    // R8: inverted all-zero byte yields all-ones line bits in both directions
    run_xfer(1'b0, 1'b0, 1'b1, 8'd1, 8'h00, 8'h00, 1'b0);

    repeat (4) @(negedge clk);
    chk(sck === 1'b1 && rx_valid === 1'b0, "R1", "final idle", {sck, rx_valid}, 2'b10);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule